// File: doc/BRIEF.md
# Vectored Interrupt Collector

This block watches a bank of level-sensitive interrupt inputs and drives one interrupt request toward a processor. Software gives each input an enable bit and a two-bit priority level in a per-source control word. Whenever an enabled input is high and no interrupt is being serviced, the request line goes high. Software reads a status word to take the interrupt. That read returns the number of the winning source, latches it, and drops the request until software writes a level acknowledge.

Every register is reached through a 16-byte window. The first word of the window is the plain address. The second word ORs the written bits into the register. The third word clears the written bits. Reads at any word of the window return the plain value. This gives software atomic mask and unmask of a single source. A control word has a bit that puts every source back to priority level 0, for use at start-up. A vector word holds whatever software writes there, so the service routine can record which source it is handling.

Top module: `irq_collector`

## Requirements
- R1: After reset, the request line is low, every enable and priority level is 0, and the status and vector words read 0.
- R2: Address bits [3:2] select the access type within a register window: 0 replaces the value, 1 ORs the written bits in, 2 clears the written bits, and 3 ignores the write. Reads at every word of a window return the plain value.
- R3: The control word of source n sits at 0x120 + 16·n. Bits [1:0] hold the priority level, bit 2 holds the enable, and all other bits read 0.
- R4: The request line is high in the same cycle that any input is high with its enable set, provided no interrupt is in service.
- R5: Among the inputs that are both high and enabled, the one with the highest level wins. When levels are equal, the lowest source number wins.
- R6: A read of the status word (0x70) while the request line is high returns the winner's number and takes the interrupt. From the next cycle the request line stays low, even if inputs change, until the interrupt is acknowledged.
- R7: At all other times a status read returns the number latched at the last take, and that number does not change while the interrupt is in service.
- R8: A write to the acknowledge word (0x10) ends the service only if the write uses the plain or OR access type and the written value has bit L set, where L is the level of the source in service. Acknowledge writes made while nothing is in service, or with the wrong bit, or through the clear access type, have no effect.
- R9: The vector word (0x0) stores all 32 bits and follows the access rules of R2.
- R10: A write that sets bit 31 of the control word (0x20), through the plain or OR access type, returns every source's level to 0 and keeps its enable. The control word reads 0.
- R11: Reads of addresses that match no register return 0. Writes to those addresses, including the control-word slots past the last source, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt inputs |
| addr_i | input | AW | Register byte address |
| wr_i | input | 1 | Write strobe, acted on at the clock edge |
| rd_i | input | 1 | Read strobe; a status read takes the interrupt at the edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the interrupt inputs change synchronously to the clock. They also assume that software holds a read or write strobe for exactly one edge. The bench meets both conditions: it changes inputs and strobes only on the falling edge, and it releases each strobe after a single rising edge. It runs the full service handshake once for every non-zero input pattern of an eight-source configuration. It does this under three settings: all sources enabled at level 0, a partial enable mask, and mixed levels. At each step it computes the winner from the requirement.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NSRC = 128,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [AW-1:0] A_VEC  = AW'('h000);
  localparam logic [AW-1:0] A_ACK  = AW'('h010);
  localparam logic [AW-1:0] A_CTRL = AW'('h020);
  localparam logic [AW-1:0] A_STAT = AW'('h070);
  localparam logic [AW-1:0] A_SRC0 = AW'('h120);

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] kind);
    case (kind)
      2'd0:    return wd;
      2'd1:    return old | wd;
      2'd2:    return old & ~wd;
      default: return old;
    endcase
  endfunction

  logic [NSRC-1:0] en;
  logic [1:0]      lvl [NSRC];
  logic [31:0]     vec_q;
  logic            busy_q;
  logic [IW-1:0]   act_q;
  logic [1:0]      act_lvl_q;

  logic [1:0]    kind;
  logic [AW-1:0] base, off;
  logic          src_hit;
  logic [IW-1:0] sidx;

  assign kind    = addr_i[3:2];
  assign base    = {addr_i[AW-1:4], 4'h0};
  assign off     = addr_i - A_SRC0;
  assign src_hit = (addr_i >= A_SRC0) && (int'(off[AW-1:4]) < NSRC);
  assign sidx    = off[IW+3:4];

  logic          found;
  logic [IW-1:0] win;
  logic [1:0]    win_lvl;
  always_comb begin
    found   = 1'b0;
    win     = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_i[i] && en[i] && (!found || lvl[i] > win_lvl)) begin
        found   = 1'b1;
        win     = IW'(i);
        win_lvl = lvl[i];
      end
    end
  end

  assign irq_o = found && !busy_q;

  logic        take, wr_vec, wr_ack, wr_ctrl, wr_src, ack_hit, soft_rst;
  logic [31:0] ack_bits, ctrl_w, src_old, src_new;

  assign take     = rd_i && (base == A_STAT) && irq_o;
  assign wr_vec   = wr_i && (base == A_VEC);
  assign wr_ack   = wr_i && (base == A_ACK);
  assign wr_ctrl  = wr_i && (base == A_CTRL);
  assign wr_src   = wr_i && src_hit;
  assign ack_bits = (kind == 2'd0 || kind == 2'd1) ? wdata_i : 32'h0;
  assign ack_hit  = wr_ack && busy_q && ack_bits[act_lvl_q];
  assign ctrl_w   = merge(32'h0, wdata_i, kind);
  assign soft_rst = wr_ctrl && ctrl_w[31];
  assign src_old  = {29'h0, en[sidx], lvl[sidx]};
  assign src_new  = merge(src_old, wdata_i, kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      vec_q     <= '0;
      busy_q    <= 1'b0;
      act_q     <= '0;
      act_lvl_q <= '0;
      for (int i = 0; i < NSRC; i++) lvl[i] <= 2'd0;
    end else begin
      if (wr_vec) vec_q <= merge(vec_q, wdata_i, kind);
      if (soft_rst)
        for (int i = 0; i < NSRC; i++) lvl[i] <= 2'd0;
      if (wr_src) begin
        en[sidx]  <= src_new[2];
        lvl[sidx] <= src_new[1:0];
      end
      if (take) begin
        busy_q    <= 1'b1;
        act_q     <= win;
        act_lvl_q <= win_lvl;
      end else if (ack_hit) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = 32'h0;
    if (rd_i) begin
      if (base == A_VEC)       rdata_o = vec_q;
      else if (base == A_STAT) rdata_o = 32'(take ? win : act_q);
      else if (src_hit)        rdata_o = src_old;
    end
  end

  logic lvl_any;
  always_comb begin
    lvl_any = 1'b0;
    for (int i = 0; i < NSRC; i++) lvl_any = lvl_any | (|lvl[i]);
  end

  p_req_when_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && |(src_i & en)) |-> irq_o);
  p_take_silences_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy_q && !irq_o));
  p_active_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_hit) |=> (busy_q && $stable(act_q)));
  p_idle_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !busy_q && !take) |=> !busy_q);
  p_levels_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !lvl_any);
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int P = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [N-1:0] src = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  int lvl_m [N];

  irq_collector #(.NSRC(N), .AW(12)) u_irq_collector (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #(P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1; #(P/4); d = rdata;
    @(negedge clk); rd = 0;
  endtask

  function automatic int win_of(input logic [N-1:0] p);
    int w = -1;
    for (int i = 0; i < N; i++)
      if (p[i] && (w < 0 || lvl_m[i] > lvl_m[w])) w = i;
    return w;
  endfunction

  task automatic sweep(input logic [N-1:0] enm);
    logic [31:0] d;
    for (int m = 1; m < (1 << N); m++) begin
      int w = win_of(N'(m) & enm);
      @(negedge clk); src = N'(m); #1;
      chk("R4 request", 32'(irq), 32'(w >= 0));
      if (w >= 0) begin
        bus_rd(12'h070, d);
        chk("R5/R6 winner", d, 32'(w));
        #1 chk("R6 request dropped", 32'(irq), 0);
        src = N'(m) ^ 1; #1;
        chk("R6 stays low", 32'(irq), 0);
        bus_rd(12'h074, d);
        chk("R7 latched", d, 32'(w));
        bus_wr(12'h018, 32'hF);
        #1 chk("R8 clear-type ack ignored", 32'(irq), 0);
        bus_wr(12'h010, 32'(1 << ((lvl_m[w] + 1) % 4)));
        #1 chk("R8 wrong level ignored", 32'(irq), 0);
        src = N'(m);
        bus_wr(12'h010, 32'(1 << lvl_m[w]));
        #1 chk("R8 ack re-arms", 32'(irq), 1);
      end
      src = '0;
    end
  endtask

  initial begin
    #(P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) lvl_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 request", 32'(irq), 0);
    bus_rd(12'h070, d); chk("R1 status", d, 0);
    bus_rd(12'h000, d); chk("R1 vector", d, 0);
    for (int i = 0; i < N; i++) begin
      bus_rd(12'(12'h120 + 16 * i), d); chk("R1 source word", d, 0);
    end

    for (int i = 0; i < N; i++) begin
      logic [11:0] a = 12'(12'h120 + 16 * i);
      bus_wr(a, 32'hFFFF_FFFF);
      for (int k = 0; k < 4; k++) begin
        bus_rd(a + 12'(4 * k), d); chk("R2/R3 alias read", d, 7);
      end
      bus_wr(a + 12'h8, 32'h4); bus_rd(a, d); chk("R2 clear enable", d, 3);
      bus_wr(a + 12'h4, 32'h4); bus_rd(a, d); chk("R2 set enable", d, 7);
      bus_wr(a + 12'h8, 32'h3); bus_rd(a, d); chk("R2 clear level", d, 4);
      bus_wr(a + 12'hC, 32'h0); bus_rd(a, d); chk("R2 slot 3 ignored", d, 4);
      bus_wr(a, 32'h0);         bus_rd(a, d); chk("R3 plain write", d, 0);
    end

    bus_wr(12'h000, 32'hA5A5_0F0F); bus_rd(12'h000, d); chk("R9 plain", d, 32'hA5A5_0F0F);
    bus_wr(12'h004, 32'h0000_F0F0); bus_rd(12'h008, d); chk("R9 or", d, 32'hA5A5_FFFF);
    bus_wr(12'h008, 32'hA5A5_0000); bus_rd(12'h004, d); chk("R9 clear", d, 32'h0000_FFFF);

    bus_rd(12'h030, d); chk("R11 hole", d, 0);
    bus_wr(12'(12'h120 + 16 * N), 32'hFFFF_FFFF);
    bus_rd(12'(12'h120 + 16 * N), d); chk("R11 past last source", d, 0);
    bus_rd(12'(12'h120 + 16 * (N - 1)), d); chk("R11 last source untouched", d, 0);

    for (int i = 0; i < N; i++) bus_wr(12'(12'h124 + 16 * i), 32'h4);
    sweep('1);

    for (int i = 0; i < N; i++)
      bus_wr(12'(12'h120 + 16 * i), ((8'hA5 >> i) & 1) ? 32'h4 : 32'h0);
    sweep(8'hA5);

    for (int i = 0; i < N; i++) begin
      lvl_m[i] = (i * 3) % 4;
      bus_wr(12'(12'h120 + 16 * i), 32'(4 | lvl_m[i]));
    end
    sweep('1);

    bus_wr(12'h010, 32'hF);
    @(negedge clk); src = 8'h10; #1;
    chk("R8 idle ack ignored", 32'(irq), 1);
    bus_rd(12'h070, d); chk("R8 take after idle ack", d, 4);
    #1 chk("R8 in service after idle ack", 32'(irq), 0);
    bus_wr(12'h010, 32'h1);
    src = '0;

    bus_wr(12'h028, 32'h8000_0000);
    bus_rd(12'h150, d); chk("R10 clear type no reset", d, 32'(4 | lvl_m[3]));
    bus_wr(12'h024, 32'h8000_0000);
    bus_rd(12'h020, d); chk("R10 control reads 0", d, 0);
    for (int i = 0; i < N; i++) begin
      bus_rd(12'(12'h120 + 16 * i), d); chk("R10 level zero enable kept", d, 4);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule